// File: doc/BRIEF.md
# Programmable Timer Time-Base

This block is the counting core of a general-purpose timer. A prescaler divides the clock into count ticks. A 16-bit counter steps on each tick. It can count up or down, or alternate between the two, and it turns around or wraps at a programmable limit. When the counter wraps, or when software asks for it, the block raises an update. An update reloads the limit and the prescale divisor from their staged copies and can set a sticky update flag. One-pulse operation stops the counter at the first update.

Software reaches the block through a synchronous port. A write takes effect at the clock edge where `wr_en` is sampled. A read returns its data one cycle after `rd_en`. A single compare channel sets a sticky flag when the counter steps onto the compare value. In the alternating modes, the direction of that step decides whether the flag is set. A separate divider produces a one-cycle strobe every 1, 2 or 4 clocks, which filter and dead-time logic can use.

Register map (3-bit address): 0 control, 1 status, 2 command, 3 counter, 4 prescale, 5 limit, 6 compare. Control bits: 0 run, 1 update off, 2 wrap-only flag, 3 one-pulse, 4 direction down, 6:5 count mode, 7 buffered limit, 9:8 strobe divide, 11 flag in counter bit 31. Status bits: 0 update flag, 1 compare flag. Command bit 0 requests a software update.

Top module: `tmr_timebase`

## Requirements
- R1: The counter and the prescaler advance only while control bit 0 (run) is 1. With a prescale shadow of P, the counter takes one step every P+1 clocks. Writing the prescale register changes the shadow only at an update.
- R2: In mode 00 the counter counts up when control bit 4 is 0, stepping from the limit to 0. It counts down when bit 4 is 1, stepping from 0 to the limit. Each such wrap is an update source.
- R3: Writing 1 to command bit 0 restarts the prescaler and the counter one cycle later. The counter restarts at 0, or at the limit when counting down in mode 00. This request is also an update source.
- R4: While control bit 1 is 1, no update takes place. The shadows keep their values and the update flag is not set. A software request still restarts the counter.
- R5: When control bit 2 is 0, every update sets status bit 0. When it is 1, only a counter wrap sets status bit 0.
- R6: When control bit 3 is 1, the update clears the run bit and the counter stops.
- R7: Modes 01, 10 and 11 count up to the limit and then down to 0, alternating. In these modes control bit 4 reads back the current direction (1 = down).
- R8: Status bit 1 is set when a step lands on the compare value. Mode 00 sets it in either direction, mode 01 only on downward steps, mode 10 only on upward steps, and mode 11 on both.
- R9: While the counter runs in mode 00, a control write that selects a nonzero mode is dropped in full.
- R10: With control bit 7 at 0, a limit write reaches the shadow at once. With it at 1, the limit shadow changes only at an update.
- R11: `smp_en` pulses once every 1, 2 or 4 clocks for control bits 9:8 = 00, 01, 10. Code 11 acts as 00.
- R12: With control bit 11 at 1, counter reads carry the update flag in bit 31. Otherwise bit 31 reads 0.
- R13: The status flags stay set until a status write clears each flag whose bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| upd_flag | output | 1 | Sticky update flag |
| cmp_flag | output | 1 | Sticky compare flag |
| smp_en | output | 1 | Divided sampling strobe |

## Verification
The bench stages a new limit while updates are off and runs past the old limit. A design that loads the shadow anyway would count on instead of wrapping. It steps through the alternating turnaround with a compare value on both sides of the peak. A design that gates the compare flag by the wrong direction sets it one phase early or never. The bench also checks that a software update with the wrap-only flag mode leaves the flag clear, and that one-pulse mode stops the counter at 0 after one period. It tries a mode change while running and reads the control register back before stopping, so a design that accepts the write is caught.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_STAT = 3'd1;
  localparam logic [2:0] ADR_CMD  = 3'd2;
  localparam logic [2:0] ADR_CNT  = 3'd3;
  localparam logic [2:0] ADR_PSC  = 3'd4;
  localparam logic [2:0] ADR_ARL  = 3'd5;
  localparam logic [2:0] ADR_CMP  = 3'd6;

  typedef enum logic [1:0] {
    CM_EDGE = 2'b00,
    CM_DOWN = 2'b01,
    CM_UP   = 2'b10,
    CM_BOTH = 2'b11
  } cnt_mode_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         reinit,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] pcnt;

  assign tick = run && !reinit && (pcnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || reinit) pcnt <= '0;
    else if (run)      pcnt <= (pcnt >= limit) ? '0 : pcnt + W'(1);
  end
endmodule

// File: rtl/tmr_stepper.sv
module tmr_stepper #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         reinit,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         center,
  input  logic         edge_down,
  input  logic [W-1:0] arl,
  output logic [W-1:0] cnt,
  output logic         dn,
  output logic         wrap,
  output logic [W-1:0] nxt,
  output logic         nxt_dn
);
  always_comb begin
    nxt    = cnt;
    nxt_dn = dn;
    wrap   = 1'b0;
    if (!center) begin
      nxt_dn = edge_down;
      if (edge_down) begin
        if (cnt == '0) begin nxt = arl; wrap = 1'b1; end
        else nxt = cnt - W'(1);
      end else begin
        if (cnt >= arl) begin nxt = '0; wrap = 1'b1; end
        else nxt = cnt + W'(1);
      end
    end else if (!dn) begin
      if (cnt >= arl) begin
        nxt    = (arl == '0) ? '0 : cnt - W'(1);
        nxt_dn = 1'b1;
        wrap   = 1'b1;
      end else nxt = cnt + W'(1);
    end else begin
      if (cnt == '0) begin
        nxt    = (arl == '0) ? '0 : W'(1);
        nxt_dn = 1'b0;
        wrap   = 1'b1;
      end else nxt = cnt - W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      dn  <= 1'b0;
    end else if (reinit) begin
      cnt <= (!center && edge_down) ? arl : '0;
      dn  <= !center && edge_down;
    end else if (load) begin
      cnt <= load_val;
      if (!center) dn <= edge_down;
    end else if (step) begin
      cnt <= nxt;
      dn  <= nxt_dn;
    end else if (!center) begin
      dn <= edge_down;
    end
  end
endmodule

// File: rtl/tmr_sdiv.sv
module tmr_sdiv #(
  parameter int DW = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] code,
  output logic       en
);
  logic [DW-1:0] dv;
  logic [DW-1:0] lim;

  always_comb begin
    case (code)
      2'b01:   lim = DW'(1);
      2'b10:   lim = DW'(3);
      default: lim = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dv <= '0;
      en <= 1'b0;
    end else begin
      dv <= (dv >= lim) ? '0 : dv + DW'(1);
      en <= (dv >= lim);
    end
  end
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [31:0]  rdata,
  output logic         upd_flag,
  output logic         cmp_flag,
  output logic         smp_en
);
  localparam int PADW = 31 - W;

  logic         c_run, c_udis, c_urs, c_opm, c_edir, c_arpe, c_remap;
  cnt_mode_e    c_mode;
  logic [1:0]   c_sdiv;
  logic [W-1:0] psc_pre, psc_sh, arl_pre, arl_sh, cmp_val;
  logic         ug_q;

  logic         tick, wrap, dn, nxt_dn, center, uev, uev_wrap, hit_ok;
  logic [W-1:0] cnt, nxt;

  logic wr_ctrl, wr_stat, wr_cnt, wr_arl, ctrl_blk;

  assign wr_ctrl  = wr_en && (addr == ADR_CTRL);
  assign wr_stat  = wr_en && (addr == ADR_STAT);
  assign wr_cnt   = wr_en && (addr == ADR_CNT);
  assign wr_arl   = wr_en && (addr == ADR_ARL);
  assign ctrl_blk = wr_ctrl && c_run && (c_mode == CM_EDGE) && (wdata[6:5] != 2'b00);
  assign center   = (c_mode != CM_EDGE);

  tmr_prescale #(.W(W)) u_psc (
    .clk(clk), .rst(rst), .run(c_run), .reinit(ug_q), .limit(psc_sh), .tick(tick)
  );

  tmr_stepper #(.W(W)) u_step (
    .clk(clk), .rst(rst), .step(tick), .reinit(ug_q), .load(wr_cnt),
    .load_val(wdata), .center(center), .edge_down(c_edir), .arl(arl_sh),
    .cnt(cnt), .dn(dn), .wrap(wrap), .nxt(nxt), .nxt_dn(nxt_dn)
  );

  tmr_sdiv #(.DW(2)) u_sdiv (
    .clk(clk), .rst(rst), .code(c_sdiv), .en(smp_en)
  );

  assign uev_wrap = tick && wrap;
  assign uev      = !c_udis && (ug_q || uev_wrap);

  always_comb begin
    case (c_mode)
      CM_DOWN: hit_ok = nxt_dn;
      CM_UP:   hit_ok = !nxt_dn;
      default: hit_ok = 1'b1;
    endcase
  end

  // control register and command strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      c_run <= 1'b0; c_udis <= 1'b0; c_urs <= 1'b0; c_opm <= 1'b0;
      c_edir <= 1'b0; c_mode <= CM_EDGE; c_arpe <= 1'b0;
      c_sdiv <= 2'b00; c_remap <= 1'b0; ug_q <= 1'b0;
    end else begin
      ug_q <= wr_en && (addr == ADR_CMD) && wdata[0];
      if (wr_ctrl && !ctrl_blk) begin
        c_run   <= wdata[0];
        c_udis  <= wdata[1];
        c_urs   <= wdata[2];
        c_opm   <= wdata[3];
        c_edir  <= wdata[4];
        c_mode  <= cnt_mode_e'(wdata[6:5]);
        c_arpe  <= wdata[7];
        c_sdiv  <= wdata[9:8];
        c_remap <= wdata[11];
      end else if (uev && c_opm) begin
        c_run <= 1'b0;
      end
    end
  end

  // staged and shadow values
  always_ff @(posedge clk) begin
    if (rst) begin
      psc_pre <= '0; psc_sh <= '0; arl_pre <= '0; arl_sh <= '0; cmp_val <= '0;
    end else begin
      if (wr_en && addr == ADR_PSC) psc_pre <= wdata;
      if (wr_arl)                   arl_pre <= wdata;
      if (wr_en && addr == ADR_CMP) cmp_val <= wdata;
      if (uev) psc_sh <= psc_pre;
      if (wr_arl && !c_arpe) arl_sh <= wdata;
      else if (uev)          arl_sh <= arl_pre;
    end
  end

  // sticky flags
  always_ff @(posedge clk) begin
    if (rst) begin
      upd_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (uev && (uev_wrap || !c_urs)) upd_flag <= 1'b1;
      else if (wr_stat && !wdata[0])   upd_flag <= 1'b0;
      if (tick && (nxt == cmp_val) && hit_ok) cmp_flag <= 1'b1;
      else if (wr_stat && !wdata[1])          cmp_flag <= 1'b0;
    end
  end

  // read port
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        ADR_CTRL: rdata <= {20'd0, c_remap, 1'b0, c_sdiv, c_arpe, c_mode,
                            (center ? dn : c_edir), c_opm, c_urs, c_udis, c_run};
        ADR_STAT: rdata <= {30'd0, cmp_flag, upd_flag};
        ADR_CNT:  rdata <= {c_remap && upd_flag, {PADW{1'b0}}, cnt};
        ADR_PSC:  rdata <= 32'(psc_pre);
        ADR_ARL:  rdata <= 32'(arl_pre);
        ADR_CMP:  rdata <= 32'(cmp_val);
        default:  rdata <= '0;
      endcase
    end
  end

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!c_run && !ug_q && !wr_cnt) |=> $stable(cnt)); // R1
  AST_NO_FLAG_WHEN_UDIS: assert property (@(posedge clk) disable iff (rst)
    (c_udis && !upd_flag) |=> !upd_flag); // R4
  AST_SHADOW_KEPT_UDIS: assert property (@(posedge clk) disable iff (rst)
    (c_udis && c_arpe) |=> $stable(arl_sh)); // R4
  AST_ONE_PULSE_STOP: assert property (@(posedge clk) disable iff (rst)
    (c_opm && uev && !wr_ctrl) |=> !c_run); // R6
  AST_MODE_SWITCH_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (c_run && c_mode == CM_EDGE && wr_ctrl && wdata[6:5] != 2'b00) |=> (c_mode == CM_EDGE)); // R9
endmodule

// File: tb/sim_tmr_timebase.sv
module sim_tmr_timebase;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_CMD = 3'd2, A_CNT = 3'd3,
                         A_PSC = 3'd4, A_ARL = 3'd5, A_CMP = 3'd6;
  localparam logic [15:0] RUN = 16'h1, UDIS = 16'h2, URS = 16'h4, OPM = 16'h8,
                          DIRD = 16'h10, CM1 = 16'h20, CM2 = 16'h40,
                          ARPE = 16'h80, REMAP = 16'h800;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [31:0] rdata;
  logic upd_flag, cmp_flag, smp_en;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] q_exp[$], q_msk[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  tmr_timebase u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                   .wdata(wdata), .rdata(rdata), .upd_flag(upd_flag),
                   .cmp_flag(cmp_flag), .smp_en(smp_en));

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input logic [31:0] m,
                    input string tag);
    q_exp.push_back(e); q_msk.push_back(m); q_tag.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ug();
    wr(A_CMD, 16'h1);
    @(negedge clk);
  endtask

  task automatic run_ticks(input logic [15:0] c, input int t);
    wr(A_CTRL, c | RUN);
    repeat (t - 1) @(negedge clk);
    wr(A_CTRL, c);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (q_exp.size() != 0) begin
          logic [31:0] e, m;
          string t;
          e = q_exp.pop_front(); m = q_msk.pop_front(); t = q_tag.pop_front();
          n_chk++;
          if ((rdata & m) !== (e & m)) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, rdata & m, e & m);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd(A_CTRL, 0, '1, "R1 reset control");
    rd(A_STAT, 0, '1, "R13 reset status");
    rd(A_CNT, 0, '1, "R1 reset counter");

    // R2 up-count wrap, edge-mode compare at 0
    wr(A_ARL, 4); wr(A_CNT, 0);
    run_ticks(0, 7);
    rd(A_CNT, 2, '1, "R2 up count after wrap");
    rd(A_STAT, 1, 1, "R2 wrap sets update flag");
    rd(A_STAT, 2, 2, "R8 edge mode compare");
    wr(A_STAT, 0);
    rd(A_STAT, 0, '1, "R13 flags cleared");

    // R2 down-count
    wr(A_CNT, 0);
    run_ticks(DIRD, 3);
    rd(A_CNT, 2, '1, "R2 down count after underflow");
    rd(A_STAT, 1, 1, "R2 underflow sets update flag");
    rd(A_CTRL, DIRD, '1, "R2 edge direction readback");

    // R3 / R5 software update and source filter
    wr(A_STAT, 0); wr(A_CTRL, URS); wr(A_CNT, 3);
    ug();
    rd(A_CNT, 0, '1, "R3 restart on software update");
    rd(A_STAT, 0, 1, "R5 software update filtered");
    wr(A_CTRL, 0);
    ug();
    rd(A_STAT, 1, 1, "R5 software update sets flag");

    // R4 / R10 update disabled, buffered limit held
    wr(A_STAT, 0); wr(A_CTRL, UDIS | ARPE); wr(A_ARL, 9); wr(A_CNT, 3);
    ug();
    rd(A_CNT, 0, '1, "R4 restart while updates off");
    rd(A_STAT, 0, 1, "R4 no flag while updates off");
    rd(A_ARL, 9, '1, "R10 staged limit readback");
    run_ticks(UDIS | ARPE, 7);
    rd(A_CNT, 2, '1, "R4 shadow kept old limit");
    rd(A_STAT, 0, 1, "R4 wrap flag suppressed");
    wr(A_CTRL, ARPE);
    ug();
    run_ticks(ARPE, 7);
    rd(A_CNT, 7, '1, "R10 buffered limit loaded at update");
    rd(A_STAT, 1, 1, "R3 update flag after request");

    // R10 immediate limit
    wr(A_CTRL, 0); wr(A_ARL, 5); wr(A_CNT, 0);
    run_ticks(0, 7);
    rd(A_CNT, 1, '1, "R10 unbuffered limit immediate");

    // R6 one-pulse
    wr(A_ARL, 3); wr(A_CNT, 0); wr(A_STAT, 0);
    wr(A_CTRL, OPM | RUN);
    repeat (10) @(negedge clk);
    rd(A_CNT, 0, '1, "R6 counter stopped at wrap");
    rd(A_CTRL, OPM, '1, "R6 run cleared");
    rd(A_STAT, 1, 1, "R6 update flag");

    // R1 prescaler
    wr(A_CTRL, 0); wr(A_ARL, 9); wr(A_PSC, 2);
    ug();
    run_ticks(0, 9);
    repeat (4) @(negedge clk);
    rd(A_CNT, 3, '1, "R1 prescale divide by 3");
    rd(A_PSC, 2, '1, "R1 prescale readback");
    wr(A_PSC, 0);
    ug();

    // R7 / R8 alternating modes
    wr(A_ARL, 3); wr(A_CMP, 2); wr(A_CTRL, CM1);
    ug();
    wr(A_STAT, 0);
    run_ticks(CM1, 2);
    rd(A_STAT, 0, 2, "R8 mode01 ignores upward hit");
    rd(A_CTRL, CM1, '1, "R7 direction reads up");
    rd(A_CNT, 2, '1, "R7 count rising");
    run_ticks(CM1, 2);
    rd(A_CNT, 2, '1, "R7 turnaround at limit");
    rd(A_CTRL, CM1 | DIRD, '1, "R7 direction reads down");
    rd(A_STAT, 2, 2, "R8 mode01 downward hit");
    wr(A_CTRL, CM2); wr(A_STAT, 0);
    run_ticks(CM2, 2);
    rd(A_STAT, 0, 2, "R8 mode10 ignores downward pass");
    run_ticks(CM2, 2);
    rd(A_STAT, 2, 2, "R8 mode10 upward hit");
    rd(A_CNT, 2, '1, "R7 turnaround at zero");

    // R9 blocked mode change while running
    wr(A_CTRL, 0); wr(A_CNT, 0);
    wr(A_CTRL, RUN);
    wr(A_CTRL, RUN | CM1);
    rd(A_CTRL, RUN, '1, "R9 mode change dropped");
    wr(A_CTRL, 0);

    // R12 flag in counter bit 31
    ug();
    wr(A_CTRL, REMAP);
    rd(A_CNT, 32'h8000_0000, '1, "R12 flag in bit 31");
    wr(A_CTRL, 0);
    rd(A_CNT, 0, '1, "R12 bit 31 clear");

    // R11 sampling strobe
    for (int code = 0; code < 4; code++) begin
      int cnt_en;
      wr(A_CTRL, 16'(code << 8));
      repeat (6) @(negedge clk);
      cnt_en = 0;
      for (int i = 0; i < 8; i++) begin
        if (smp_en) cnt_en++;
        @(negedge clk);
      end
      chk(cnt_en, (code == 1) ? 4 : (code == 2) ? 2 : 8, "R11 strobe rate");
    end

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule